// File: doc/BRIEF.md
# Paged DMA Address Translator

This block is a DMA channel engine that moves a requested number of bytes between a device-side word stream and system memory. Software programs one of several channel slots with a control word, a byte count and a logical start address, and sets a translation table base and a table size in bytes. A device side then asks for a transfer on a channel. The engine checks that the channel is enabled and that the requested direction matches the channel's programmed direction. It clips the length to the channel count and walks the logical range one 4 KiB page at a time.

For each page the engine reads the page's translation entry from memory through a master port. Each entry is 8 bytes, and the engine uses its first 32-bit word as the physical frame address. The engine then moves the page's share of the data one 32-bit word per beat. When memory is read, each word goes out on a device output stream. When memory is written, each word comes from a device input stream. Every data and memory interface uses valid/ready handshakes. A source that raises valid holds it, and holds its payload stable, until the cycle in which ready is also high. The engine's ready outputs never depend on the partner's valid. Either side may stall for any number of cycles. Control pins (start, busy, done) and the register port are plain signals.

Top module: `dma_page_xlat`

## Requirements
- R1: After reset every register reads zero, and busy, done, mem_valid, dev_out_valid and dev_in_ready are low.
- R2: Register map. Byte offset 0x000 is the table base and 0x008 is the table size; both are read/write. Offset 0x010 is a read-only error source word whose bit n belongs to channel n. Channel n, word w sits at 0x100 + 32·n + 8·w. The words are w=1 control, w=2 byte count and w=3 logical address, all read/write. Word 0 and every unmapped offset read zero, and writes to them are ignored.
- R3: Control bit 0 is enable and bit 1 selects memory-to-device. Bits 8 (complete), 9 (request error) and 10 (address error) are flags. When a request is accepted, bits 8–10 of its channel are cleared.
- R4: If the channel is not enabled, or req_to_dev differs from control bit 1, the engine does three things. It sets control bit 9 and sets the sticky error source bit of that channel. It moves no data and does not change the count. done pulses in the cycle after the request.
- R5: The transfer length is the smaller of req_len and the channel count, with bits 1:0 cleared. The logical address is taken with bits 1:0 cleared.
- R6: For each page the engine issues one memory read at (base + 8·(logical address >> 12)) with bit 31 forced to 0. The returned word is the page frame.
- R7: Data beats use physical address frame + (logical address & 0xFFF). A new table read is made whenever the logical address crosses a 4096-byte boundary.
- R8: If the page index is greater than or equal to table size / 8, the transfer stops before that page's table read.
- R9: When a transfer ends, control bit 8 is set and the count is reduced by the bytes actually moved. done is high for exactly one cycle.
- R10: When memory is read, the words appear on dev_out in logical order. When memory is written, dev_in words are written in order. mem_valid and dev_out_valid stay high with a stable payload until accepted.
- R11: busy is high from the cycle after an accepted request until done. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_start | input | 1 | Transfer request strobe |
| req_chan | input | 3 | Channel of the request |
| req_to_dev | input | 1 | 1: memory to device, 0: device to memory |
| req_len | input | 32 | Requested byte count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory beat accepted |
| mem_write | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Physical byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |
| dev_out_valid | output | 1 | Word to device valid |
| dev_out_ready | input | 1 | Device accepts word |
| dev_out_data | output | 32 | Word to device |
| dev_in_valid | input | 1 | Word from device valid |
| dev_in_ready | output | 1 | Engine accepts word |
| dev_in_data | input | 32 | Word from device |

## Verification
The hardest case to reach is a transfer that crosses a page boundary and then runs into the table size before the byte count is used up, while both memory and device apply random back-pressure. Only that case checks together the per-page table reads, the early stop and the count write-back of the moved bytes. The stimulus reaches it in two ways. Directed runs use start addresses just below a page end and small table sizes. Random runs draw start pages, lengths and table sizes so that their ranges often straddle the limit, and every ready signal toggles randomly. A request issued in the middle of a long transfer checks the refusal rule.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;
  localparam int WORD_BYTES  = 4;
  localparam int ENTRY_SHIFT = 3;

  // control word fields
  localparam int CTL_EN    = 0;
  localparam int CTL_TODEV = 1;
  localparam int CTL_TC    = 8;
  localparam int CTL_MERR  = 9;
  localparam int CTL_AERR  = 10;

  // channel word selectors
  localparam logic [1:0] WSEL_CTL   = 2'd1;
  localparam logic [1:0] WSEL_CNT   = 2'd2;
  localparam logic [1:0] WSEL_LADDR = 2'd3;

  // global register offsets
  localparam int OFF_BASE   = 'h000;
  localparam int OFF_LIMIT  = 'h008;
  localparam int OFF_ERRSRC = 'h010;

  typedef enum logic [2:0] {
    W_IDLE, W_LOOKUP, W_FETCH, W_RDMEM, W_PUSH, W_PULL, W_WRMEM, W_FINISH
  } walk_state_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_xlat_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int CHW = $clog2(NCH),
  parameter int RAW = CHW + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [RAW-1:0]   host_addr,
  input  logic [AW-1:0]    host_wdata,
  output logic [AW-1:0]    host_rdata,
  input  logic [CHW-1:0]   eng_ch,
  input  logic             eng_clr_flags,
  input  logic             eng_set_err,
  input  logic             eng_finish,
  input  logic [AW-1:0]    eng_moved,
  output logic [1:0]       ch_mode,
  output logic [AW-1:0]    ch_count,
  output logic [AW-1:0]    ch_laddr,
  output logic [AW-1:0]    tbl_base,
  output logic [AW-4:0]    tbl_entries
);
  logic [AW-1:0]  ctl_q [NCH];
  logic [AW-1:0]  cnt_q [NCH];
  logic [AW-1:0]  adr_q [NCH];
  logic [AW-1:0]  base_q, lim_q;
  logic [NCH-1:0] err_q;

  logic           win, aligned;
  logic [CHW-1:0] hch;
  logic [1:0]     hw;

  assign win     = host_addr[RAW-1];
  assign hch     = host_addr[5 +: CHW];
  assign hw      = host_addr[4:3];
  assign aligned = (host_addr[2:0] == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        ctl_q[c] <= '0;
        cnt_q[c] <= '0;
        adr_q[c] <= '0;
      end
      base_q <= '0;
      lim_q  <= '0;
      err_q  <= '0;
    end else begin
      if (host_wr && !win) begin
        if (host_addr == RAW'(OFF_BASE))  base_q <= host_wdata;
        if (host_addr == RAW'(OFF_LIMIT)) lim_q  <= host_wdata;
      end
      for (int c = 0; c < NCH; c++) begin
        if (host_wr && win && aligned && hch == CHW'(c)) begin
          case (hw)
            WSEL_CTL:   ctl_q[c] <= host_wdata;
            WSEL_CNT:   cnt_q[c] <= host_wdata;
            WSEL_LADDR: adr_q[c] <= host_wdata;
            default:    ;
          endcase
        end
        // engine updates take priority over a same-cycle host write
        if (eng_ch == CHW'(c)) begin
          if (eng_clr_flags) ctl_q[c][CTL_AERR:CTL_TC] <= 3'b000;
          if (eng_set_err)   ctl_q[c][CTL_MERR] <= 1'b1;
          if (eng_finish) begin
            ctl_q[c][CTL_TC] <= 1'b1;
            cnt_q[c]         <= cnt_q[c] - eng_moved;
          end
        end
      end
      if (eng_set_err) err_q[eng_ch] <= 1'b1;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (win) begin
      if (aligned) begin
        case (hw)
          WSEL_CTL:   host_rdata = ctl_q[hch];
          WSEL_CNT:   host_rdata = cnt_q[hch];
          WSEL_LADDR: host_rdata = adr_q[hch];
          default:    host_rdata = '0;
        endcase
      end
    end else if (host_addr == RAW'(OFF_BASE)) begin
      host_rdata = base_q;
    end else if (host_addr == RAW'(OFF_LIMIT)) begin
      host_rdata = lim_q;
    end else if (host_addr == RAW'(OFF_ERRSRC)) begin
      host_rdata = AW'(err_q);
    end
  end

  assign ch_mode     = ctl_q[eng_ch][CTL_TODEV:CTL_EN];
  assign ch_count    = cnt_q[eng_ch];
  assign ch_laddr    = adr_q[eng_ch];
  assign tbl_base    = base_q;
  assign tbl_entries = lim_q[AW-1:ENTRY_SHIFT];

  // error source bits never clear once set
  p_errsrc_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: rtl/dma_page_walker.sv
module dma_page_walker
  import dma_xlat_pkg::*;
#(
  parameter int AW  = 32,
  parameter int PB  = 12,
  parameter int CHW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_start,
  input  logic [CHW-1:0]  req_chan,
  input  logic            req_to_dev,
  input  logic [AW-1:0]   req_len,
  output logic            busy,
  output logic            done,
  output logic [CHW-1:0]  eng_ch,
  output logic            eng_clr_flags,
  output logic            eng_set_err,
  output logic            eng_finish,
  output logic [AW-1:0]   eng_moved,
  input  logic [1:0]      ch_mode,
  input  logic [AW-1:0]   ch_count,
  input  logic [AW-1:0]   ch_laddr,
  input  logic [AW-1:0]   tbl_base,
  input  logic [AW-4:0]   tbl_entries,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [AW-1:0]   mem_wdata,
  input  logic [AW-1:0]   mem_rdata,
  output logic            dev_out_valid,
  input  logic            dev_out_ready,
  output logic [AW-1:0]   dev_out_data,
  input  logic            dev_in_valid,
  output logic            dev_in_ready,
  input  logic [AW-1:0]   dev_in_data
);
  localparam int CW = PB + 1;
  localparam logic [CW-1:0] PAGE_BYTES = CW'(1) << PB;
  localparam logic [CW-1:0] STEP_C     = CW'(WORD_BYTES);
  localparam logic [AW-1:0] STEP_A     = AW'(WORD_BYTES);
  localparam logic [AW-1:0] WMASK      = ~AW'(WORD_BYTES - 1);

  walk_state_e    st;
  logic [CHW-1:0] cur_ch;
  logic           to_dev_q, done_q;
  logic [AW-1:0]  cur_addr, remain, moved, frame, hold;
  logic [CW-1:0]  chunk_left;

  logic [PB-1:0]  off;
  logic [CW-1:0]  to_page, first_chunk;
  logic [AW-1:0]  idx, entry_sum, entry_addr, phys, clip;
  logic           beyond, accept, chan_ok, last_word, step;

  assign off         = cur_addr[PB-1:0];
  assign to_page     = PAGE_BYTES - {1'b0, off};
  assign first_chunk = (remain < AW'(to_page)) ? remain[CW-1:0] : to_page;
  assign idx         = cur_addr >> PB;
  assign beyond      = (idx >= AW'(tbl_entries));
  assign entry_sum   = tbl_base + (idx << ENTRY_SHIFT);
  assign entry_addr  = {1'b0, entry_sum[AW-2:0]};
  assign phys        = frame + AW'(off);
  assign clip        = ((req_len < ch_count) ? req_len : ch_count) & WMASK;
  assign accept      = req_start && (st == W_IDLE);
  assign chan_ok     = ch_mode[CTL_EN] && (ch_mode[CTL_TODEV] == req_to_dev);
  assign last_word   = (chunk_left == STEP_C);
  assign step        = ((st == W_PUSH) && dev_out_ready) ||
                       ((st == W_WRMEM) && mem_ready);

  assign eng_ch        = (st == W_IDLE) ? req_chan : cur_ch;
  assign eng_clr_flags = accept;
  assign eng_set_err   = accept && !chan_ok;
  assign eng_finish    = (st == W_FINISH);
  assign eng_moved     = moved;

  assign mem_valid     = (st == W_FETCH) || (st == W_RDMEM) || (st == W_WRMEM);
  assign mem_write     = (st == W_WRMEM);
  assign mem_addr      = (st == W_FETCH) ? entry_addr : phys;
  assign mem_wdata     = hold;
  assign dev_out_valid = (st == W_PUSH);
  assign dev_out_data  = hold;
  assign dev_in_ready  = (st == W_PULL);
  assign busy          = (st != W_IDLE);
  assign done          = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= W_IDLE;
      cur_ch     <= '0;
      to_dev_q   <= 1'b0;
      cur_addr   <= '0;
      remain     <= '0;
      moved      <= '0;
      frame      <= '0;
      hold       <= '0;
      chunk_left <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (step) begin
        cur_addr   <= cur_addr + STEP_A;
        remain     <= remain - STEP_A;
        moved      <= moved + STEP_A;
        chunk_left <= chunk_left - STEP_C;
      end
      case (st)
        W_IDLE: begin
          if (accept) begin
            if (chan_ok) begin
              cur_ch   <= req_chan;
              to_dev_q <= req_to_dev;
              cur_addr <= ch_laddr & WMASK;
              remain   <= clip;
              moved    <= '0;
              st       <= W_LOOKUP;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        W_LOOKUP: st <= (remain == '0 || beyond) ? W_FINISH : W_FETCH;
        W_FETCH: begin
          if (mem_ready) begin
            frame      <= mem_rdata;
            chunk_left <= first_chunk;
            st         <= to_dev_q ? W_RDMEM : W_PULL;
          end
        end
        W_RDMEM: begin
          if (mem_ready) begin
            hold <= mem_rdata;
            st   <= W_PUSH;
          end
        end
        W_PUSH:  if (dev_out_ready) st <= last_word ? W_LOOKUP : W_RDMEM;
        W_PULL: begin
          if (dev_in_valid) begin
            hold <= dev_in_data;
            st   <= W_WRMEM;
          end
        end
        W_WRMEM: if (mem_ready) st <= last_word ? W_LOOKUP : W_PULL;
        W_FINISH: begin
          done_q <= 1'b1;
          st     <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_write) && $stable(mem_wdata)));
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid && !dev_out_ready) |=> (dev_out_valid && $stable(dev_out_data)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_entry_bit31_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_FETCH) |-> !mem_addr[AW-1]);
  p_in_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == W_RDMEM) || (st == W_WRMEM)) |-> (chunk_left != '0 && chunk_left <= to_page));
  p_fetch_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_FETCH) |-> !beyond);
  p_refuse_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_start) |=> (cur_ch == $past(cur_ch)));
  p_err_nomove_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_set_err |=> (!busy && done));
endmodule

// File: rtl/dma_page_xlat.sv
module dma_page_xlat
  import dma_xlat_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int PB  = 12,
  parameter int CHW = $clog2(NCH),
  parameter int RAW = CHW + 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  input  logic            req_start,
  input  logic [CHW-1:0]  req_chan,
  input  logic            req_to_dev,
  input  logic [AW-1:0]   req_len,
  output logic            busy,
  output logic            done,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [AW-1:0]   mem_wdata,
  input  logic [AW-1:0]   mem_rdata,
  output logic            dev_out_valid,
  input  logic            dev_out_ready,
  output logic [AW-1:0]   dev_out_data,
  input  logic            dev_in_valid,
  output logic            dev_in_ready,
  input  logic [AW-1:0]   dev_in_data
);
  logic [CHW-1:0] eng_ch;
  logic           eng_clr_flags, eng_set_err, eng_finish;
  logic [AW-1:0]  eng_moved, ch_count, ch_laddr, tbl_base;
  logic [AW-4:0]  tbl_entries;
  logic [1:0]     ch_mode;

  dma_chan_regs #(.NCH(NCH), .AW(AW), .CHW(CHW), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr(reg_wr), .host_addr(reg_addr), .host_wdata(reg_wdata),
    .host_rdata(reg_rdata),
    .eng_ch(eng_ch), .eng_clr_flags(eng_clr_flags), .eng_set_err(eng_set_err),
    .eng_finish(eng_finish), .eng_moved(eng_moved),
    .ch_mode(ch_mode), .ch_count(ch_count), .ch_laddr(ch_laddr),
    .tbl_base(tbl_base), .tbl_entries(tbl_entries)
  );

  dma_page_walker #(.AW(AW), .PB(PB), .CHW(CHW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_start(req_start), .req_chan(req_chan), .req_to_dev(req_to_dev),
    .req_len(req_len), .busy(busy), .done(done),
    .eng_ch(eng_ch), .eng_clr_flags(eng_clr_flags), .eng_set_err(eng_set_err),
    .eng_finish(eng_finish), .eng_moved(eng_moved),
    .ch_mode(ch_mode), .ch_count(ch_count), .ch_laddr(ch_laddr),
    .tbl_base(tbl_base), .tbl_entries(tbl_entries),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
    .dev_out_data(dev_out_data),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data)
  );
endmodule

// File: tb/dma_page_xlat_test.sv
module dma_page_xlat_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_start = 1'b0;
  logic [2:0]  req_chan = '0;
  logic        req_to_dev = 1'b0;
  logic [31:0] req_len = '0;
  logic        busy, done;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_out_valid;
  logic        dev_out_ready = 1'b0;
  logic [31:0] dev_out_data;
  logic        dev_in_valid = 1'b0;
  logic        dev_in_ready;
  logic [31:0] dev_in_data = '0;

  always #10 clk = ~clk;

  dma_page_xlat uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_start(req_start),
    .req_chan(req_chan), .req_to_dev(req_to_dev), .req_len(req_len),
    .busy(busy), .done(done), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_out_valid(dev_out_valid),
    .dev_out_ready(dev_out_ready), .dev_out_data(dev_out_data),
    .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data)
  );

  int total = 0;
  int bad = 0;
  int unsigned exp_cur, exp_out, in_k, wk, beats, out_beats;
  int done_cnt = 0;
  bit in_hs = 1'b0;

  localparam logic [31:0] TBL_PHYS = 32'h0001_0000;

  function automatic logic [31:0] tframe(input int unsigned i);
    return 32'h0020_0000 + i * 32'h3000 + 32'h40;
  endfunction
  function automatic logic [31:0] hashw(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] patw(input int unsigned k);
    return (k * 32'h0101_0101) ^ 32'hC0DE_0000;
  endfunction
  function automatic logic [31:0] mem_resp(input logic [31:0] a);
    if (a >= TBL_PHYS && a < TBL_PHYS + 32'h1000)
      return a[2] ? 32'h0 : tframe((a - TBL_PHYS) >> 3);
    return hashw(a);
  endfunction
  function automatic int unsigned exp_moved(input int unsigned la, input int unsigned cnt,
                                            input int unsigned len, input int unsigned lim);
    int unsigned clip, cur, m, chunk;
    clip = ((len < cnt) ? len : cnt) & ~32'd3;
    cur = la & ~32'd3;
    m = 0;
    while (m < clip) begin
      if ((cur >> 12) >= (lim >> 3)) break;
      chunk = 4096 - (cur & 32'hFFF);
      if (chunk > clip - m) chunk = clip - m;
      m += chunk;
      cur += chunk;
    end
    return m;
  endfunction
  function automatic logic [8:0] chan_reg(input int ch, input int w);
    return 9'(9'h100 + ch * 32 + w * 8);
  endfunction

  assign mem_rdata = mem_resp(mem_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // stream partners and path monitor, all at the falling edge
  always @(negedge clk) begin
    logic [31:0] e;
    mem_ready = ($urandom % 4) != 0;
    dev_out_ready = ($urandom % 3) != 0;
    if (in_hs) begin
      in_k++;
      in_hs = 1'b0;
      dev_in_valid = ($urandom % 3) != 0;
    end else if (!dev_in_valid) begin
      dev_in_valid = ($urandom % 3) != 0;
    end
    dev_in_data = patw(in_k);
    if (mem_valid === 1'b1 && mem_ready) begin
      if (!mem_write && mem_addr < 32'h0020_0000) begin
        e = TBL_PHYS + (exp_cur >> 12) * 8;
        chk("R6 table read address", mem_addr, e);
      end else begin
        e = tframe(exp_cur >> 12) + (exp_cur & 32'hFFF);
        chk("R7 data beat address", mem_addr, e);
        if (mem_write) begin
          chk("R10 written word", mem_wdata, patw(wk));
          wk++;
        end
        exp_cur += 4;
        beats++;
      end
    end
    if (dev_out_valid === 1'b1 && dev_out_ready) begin
      e = hashw(tframe(exp_out >> 12) + (exp_out & 32'hFFF));
      chk("R10 device output word", dev_out_data, e);
      exp_out += 4;
      out_beats++;
    end
    if (dev_in_valid && dev_in_ready === 1'b1) in_hs = 1'b1;
    if (done === 1'b1) done_cnt++;
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(posedge clk); #3;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #3;
    reg_wr = 1'b0;
  endtask
  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(posedge clk); #3;
    reg_addr = a;
    #1 d = reg_rdata;
  endtask
  task automatic pulse_start(input int ch, input bit todev, input logic [31:0] len);
    @(posedge clk); #3;
    req_start = 1'b1; req_chan = 3'(ch); req_to_dev = todev; req_len = len;
    @(posedge clk); #3;
    req_start = 1'b0;
  endtask
  task automatic arm(input logic [31:0] la);
    exp_cur = la & ~32'd3; exp_out = exp_cur;
    in_k = 0; wk = 0; beats = 0; out_beats = 0;
  endtask
  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(posedge clk);
  endtask

  task automatic xfer(input string tag, input int ch, input bit todev, input logic [31:0] ctl,
                      input logic [31:0] cnt, input logic [31:0] la, input logic [31:0] len,
                      input logic [31:0] lim);
    int unsigned mv;
    int d0;
    logic [31:0] v;
    wr(9'h008, lim);
    wr(chan_reg(ch, 1), ctl);
    wr(chan_reg(ch, 2), cnt);
    wr(chan_reg(ch, 3), la);
    mv = exp_moved(la, cnt, len, lim);
    arm(la);
    d0 = done_cnt;
    pulse_start(ch, todev, len);
    wait_done(d0);
    @(posedge clk);
    rd(chan_reg(ch, 2), v);
    chk({tag, " R9 count after transfer"}, v, cnt - mv);
    rd(chan_reg(ch, 1), v);
    chk({tag, " R3 flags cleared then complete set"}, v, (ctl & ~32'h700) | 32'h100);
    chk({tag, " R5 bytes moved"}, beats * 4, mv);
    if (todev) chk({tag, " R10 words delivered"}, out_beats, beats);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int d0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 mem_valid", 32'(mem_valid), 0);
    rd(9'h000, v); chk("R1 base", v, 0);
    rd(9'h008, v); chk("R1 limit", v, 0);
    rd(9'h010, v); chk("R1 error source", v, 0);
    rd(chan_reg(3, 1), v); chk("R1 control", v, 0);
    rd(chan_reg(7, 3), v); chk("R1 address", v, 0);

    // R2 register map
    wr(chan_reg(5, 2), 32'h1234_5678);
    rd(chan_reg(5, 2), v); chk("R2 count readback", v, 32'h1234_5678);
    rd(chan_reg(4, 2), v); chk("R2 neighbour untouched", v, 0);
    wr(chan_reg(5, 0), 32'hFFFF_FFFF);
    rd(chan_reg(5, 0), v); chk("R2 word 0 reads zero", v, 0);
    wr(9'h010, 32'hFF);
    rd(9'h010, v); chk("R2 error source read only", v, 0);
    wr(9'h030, 32'hAAAA_5555);
    rd(9'h030, v); chk("R2 unmapped reads zero", v, 0);
    wr(9'h000, 32'h8001_0000);
    rd(9'h000, v); chk("R2 base readback", v, 32'h8001_0000);

    // R6 R7 page crossing, memory to device, flags preset
    xfer("D1", 2, 1'b1, 32'h703, 32'h3000, 32'h0000_0FF0, 32'h40, 32'h80);
    // R5 clip to count, device to memory
    xfer("D2", 1, 1'b0, 32'h1, 32'h100, 32'h2000, 32'h400, 32'h80);
    // R5 length bits 1:0 ignored
    xfer("D3", 3, 1'b1, 32'h3, 32'h800, 32'h1000, 32'h0FE, 32'h80);
    // R8 stop at table size after a page crossing
    xfer("D4", 0, 1'b0, 32'h1, 32'h1000, 32'h2F00, 32'h400, 32'h18);
    // R9 zero length completes with nothing moved
    xfer("D5", 6, 1'b1, 32'h3, 32'h0, 32'h0, 32'h40, 32'h80);

    // R4 disabled channel
    wr(chan_reg(4, 1), 32'h500);
    wr(chan_reg(4, 2), 32'h80);
    arm(0);
    d0 = done_cnt;
    pulse_start(4, 1'b1, 32'h40);
    wait_done(d0);
    @(posedge clk);
    rd(chan_reg(4, 1), v); chk("R4 disabled flags", v, 32'h200);
    rd(chan_reg(4, 2), v); chk("R4 count unchanged", v, 32'h80);
    chk("R4 no data moved", beats, 0);
    // R4 direction mismatch
    wr(chan_reg(6, 1), 32'h1);
    d0 = done_cnt;
    pulse_start(6, 1'b1, 32'h40);
    wait_done(d0);
    @(posedge clk);
    rd(chan_reg(6, 1), v); chk("R4 mismatch flags", v, 32'h201);
    rd(9'h010, v); chk("R4 error source bits", v, 32'h50);

    // R11 start while busy is ignored
    wr(9'h008, 32'h80);
    wr(chan_reg(7, 1), 32'h701);
    wr(chan_reg(2, 1), 32'h3);
    wr(chan_reg(2, 2), 32'h200);
    wr(chan_reg(2, 3), 32'h3000);
    arm(32'h3000);
    d0 = done_cnt;
    pulse_start(2, 1'b1, 32'h200);
    chk("R11 busy during transfer", 32'(busy), 1);
    pulse_start(7, 1'b0, 32'h40);
    wait_done(d0);
    repeat (6) @(posedge clk);
    chk("R11 single done", done_cnt - d0, 1);
    rd(chan_reg(7, 1), v); chk("R11 refused channel untouched", v, 32'h701);
    chk("R11 first transfer complete", beats, 32'h80);

    // random transfers
    for (int i = 0; i < 8; i++) begin
      int ch;
      bit td;
      logic [31:0] la, len, cnt, lim;
      ch  = $urandom % 8;
      td  = $urandom % 2;
      la  = (($urandom % 6) << 12) | (($urandom % 1024) << 2);
      len = $urandom % 32'h1800;
      cnt = $urandom % 32'h1C00;
      lim = 32'h10 + ($urandom % 7) * 8;
      xfer("RND", ch, td, {30'h0, td, 1'b1}, cnt, la, len, lim);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule